// File: doc/BRIEF.md
# Paged On-Chip Expanded RAM Access Unit

This unit sits beside an 8-bit microcontroller core and serves its external-data-memory read and write requests. For each request it forms a 16-bit effective address and decides whether that address falls inside a fixed upper window, F400h to FFFFh inclusive, that is backed by 3072 bytes of on-chip RAM. Accesses inside the window are served locally. Accesses outside it leave the RAM untouched and raise a one-cycle off-chip flag, so that a separate external bus controller can carry them out.

The effective address comes from one of two sources. In pointer mode it is the full 16-bit data pointer. In paged mode the low byte comes from the core's 8-bit indirect register, and the high byte comes from a dedicated page register. That register lives in the special-function-register space at address 91h and is fully independent of any port output latch. The core reads and writes the page register through a small SFR port. All other SFR addresses are ignored by this unit.

Top module: `xram_pager`

## Requirements
- R1: With reqMode = 0 (pointer mode), the effective address is dataPtr.
- R2: With reqMode = 1 (paged mode), the effective address is {page register, reqLowAddr}.
- R3: The page register is 8 bits wide and resets to 00h. sfrRdData returns its value while sfrAddr = 91h, and returns 00h for any other sfrAddr.
- R4: An SFR write (sfrWrEn = 1) to address 91h loads sfrWrData on that clock edge. A paged request in the same cycle still uses the old page value, and requests from the next cycle on use the new value.
- R5: An SFR write to any other address, for example the port 2 latch at A0h, leaves the page register unchanged.
- R6: A request with reqValid = 1 and reqWrite = 1 to an in-window address stores wrData at RAM offset (address − F400h) on that clock edge.
- R7: A request with reqValid = 1 and reqWrite = 0 to an in-window address presents the addressed byte on rdData one cycle later. rdData holds its value until the next in-window read.
- R8: A request to an address below F400h drives offChip high for exactly the next cycle. It changes neither the RAM nor rdData.
- R9: offChip stays low in the cycle after an in-window request and in the cycle after a cycle with no request.
- R10: The window edges are exact: F3FFh is off-chip, and both F400h and FFFFh are on-chip, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe for this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMode | input | 1 | 0 = pointer mode, 1 = paged mode |
| reqLowAddr | input | 8 | Low address byte from the indirect register (paged mode) |
| dataPtr | input | 16 | Full data pointer (pointer mode) |
| wrData | input | 8 | Write data |
| sfrAddr | input | 8 | SFR address for reads and writes |
| sfrWrEn | input | 1 | SFR write strobe |
| sfrWrData | input | 8 | SFR write data |
| sfrRdData | output | 8 | SFR read data (page register at 91h, otherwise 00h) |
| rdData | output | 8 | Registered RAM read data |
| offChip | output | 1 | One-cycle pulse: the last request was outside the window |

## Verification
First the whole RAM is filled in pointer mode with a position-dependent pattern. After that, every byte that is read can be told apart from its neighbours, so an offset that is off by one, or a bit that is lost, shows up as a mismatch. Random traffic then mixes pointer-mode and paged accesses. About half of the pointers fall inside the window and the page values are biased toward F4h to FFh, so on-chip and off-chip outcomes are both frequent, and an off-chip write that leaks into RAM shows up later as a corrupted read. Directed cases probe F3FFh, F400h and FFFFh in both modes. They also cover a page write in the same cycle as a paged read, which separates old-page from new-page use, and a write to another SFR address followed by a page read-back, which shows that the page register is independent of the port latch.

// File: rtl/xram_pager_pkg.sv
package xram_pager_pkg;

  // Strobes sent from the decode/control block to the datapath each cycle.
  typedef struct packed {
    logic pageWr;   // load the page register from the SFR write bus
    logic memWr;    // write the addressed RAM byte
    logic memRd;    // capture the addressed RAM byte into rdData
    logic offHit;   // request lies outside the on-chip window
  } ctrl_strobe_t;

endpackage

// File: rtl/xram_pager_ctrl.sv
module xram_pager_ctrl
  import xram_pager_pkg::*;
#(
  parameter int          ADDR_W        = 16,
  parameter int          LOW_W         = 8,
  parameter int          SFR_W         = 8,
  parameter logic [15:0] WIN_BASE      = 16'hF400,
  parameter logic [7:0]  PAGE_SFR_ADDR = 8'h91,
  parameter int          OFF_W         = 12
) (
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic                    reqMode,
  input  logic [LOW_W-1:0]        reqLowAddr,
  input  logic [ADDR_W-1:0]       dataPtr,
  input  logic [ADDR_W-LOW_W-1:0] pageVal,
  input  logic [SFR_W-1:0]        sfrAddr,
  input  logic                    sfrWrEn,
  output ctrl_strobe_t            strobes,
  output logic [OFF_W-1:0]        memOffset,
  output logic                    sfrSelPage
);

  logic [ADDR_W-1:0] effAddr;
  logic              inWindow;

  // Mode select: full pointer, or page register joined with the low byte.
  always_comb begin
    if (reqMode) effAddr = {pageVal, reqLowAddr};
    else         effAddr = dataPtr;
  end

  assign inWindow  = (effAddr >= WIN_BASE);
  assign memOffset = OFF_W'(effAddr - WIN_BASE);

  assign sfrSelPage = (sfrAddr == PAGE_SFR_ADDR);

  always_comb begin
    strobes        = '0;
    strobes.pageWr = sfrWrEn && sfrSelPage;
    if (reqValid) begin
      strobes.memWr  = inWindow && reqWrite;
      strobes.memRd  = inWindow && !reqWrite;
      strobes.offHit = !inWindow;
    end
  end

endmodule

// File: rtl/xram_pager_dp.sv
module xram_pager_dp
  import xram_pager_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8,
  parameter int SFR_W  = 8,
  parameter int DEPTH  = 3072,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobes,
  input  logic [OFF_W-1:0]  memOffset,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SFR_W-1:0]  sfrWrData,
  input  logic              sfrSelPage,
  output logic [PAGE_W-1:0] pageVal,
  output logic [SFR_W-1:0]  sfrRdData,
  output logic [DATA_W-1:0] rdData,
  output logic              offChip
);

  logic [DATA_W-1:0] ramArr [DEPTH];
  logic [PAGE_W-1:0] pageQ;

  // Page register: separate from every port latch.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pageQ <= '0;
    else if (strobes.pageWr) pageQ <= PAGE_W'(sfrWrData);
  end

  assign pageVal   = pageQ;
  assign sfrRdData = sfrSelPage ? SFR_W'(pageQ) : '0;

  // RAM storage, no reset.
  always_ff @(posedge clk) begin
    if (strobes.memWr) ramArr[memOffset] <= wrData;
  end

  // Registered read port and off-chip pulse.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      offChip <= 1'b0;
    end else begin
      if (strobes.memRd) rdData <= ramArr[memOffset];
      offChip <= strobes.offHit;
    end
  end

endmodule

// File: rtl/xram_pager.sv
module xram_pager
  import xram_pager_pkg::*;
#(
  parameter int          ADDR_W        = 16,
  parameter int          LOW_W         = 8,
  parameter int          DATA_W        = 8,
  parameter int          SFR_W         = 8,
  parameter logic [15:0] WIN_BASE      = 16'hF400,
  parameter logic [7:0]  PAGE_SFR_ADDR = 8'h91
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqMode,
  input  logic [LOW_W-1:0]  reqLowAddr,
  input  logic [ADDR_W-1:0] dataPtr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SFR_W-1:0]  sfrAddr,
  input  logic              sfrWrEn,
  input  logic [SFR_W-1:0]  sfrWrData,
  output logic [SFR_W-1:0]  sfrRdData,
  output logic [DATA_W-1:0] rdData,
  output logic              offChip
);

  localparam int PAGE_W = ADDR_W - LOW_W;
  localparam int DEPTH  = (2 ** ADDR_W) - int'(WIN_BASE);
  localparam int OFF_W  = $clog2(DEPTH);

  ctrl_strobe_t      strobes;
  logic [OFF_W-1:0]  memOffset;
  logic [PAGE_W-1:0] pageVal;
  logic              sfrSelPage;

  xram_pager_ctrl #(
    .ADDR_W(ADDR_W), .LOW_W(LOW_W), .SFR_W(SFR_W),
    .WIN_BASE(WIN_BASE), .PAGE_SFR_ADDR(PAGE_SFR_ADDR), .OFF_W(OFF_W)
  ) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqMode(reqMode),
    .reqLowAddr(reqLowAddr), .dataPtr(dataPtr), .pageVal(pageVal),
    .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn),
    .strobes(strobes), .memOffset(memOffset), .sfrSelPage(sfrSelPage)
  );

  xram_pager_dp #(
    .PAGE_W(PAGE_W), .DATA_W(DATA_W), .SFR_W(SFR_W),
    .DEPTH(DEPTH), .OFF_W(OFF_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .memOffset(memOffset),
    .wrData(wrData), .sfrWrData(sfrWrData), .sfrSelPage(sfrSelPage),
    .pageVal(pageVal), .sfrRdData(sfrRdData), .rdData(rdData),
    .offChip(offChip)
  );

endmodule

// File: rtl/xram_pager_chk.sv
module xram_pager_chk #(
  parameter logic [15:0] WIN_BASE      = 16'hF400,
  parameter logic [7:0]  PAGE_SFR_ADDR = 8'h91
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic        reqMode,
  input logic [7:0]  reqLowAddr,
  input logic [15:0] dataPtr,
  input logic [7:0]  sfrAddr,
  input logic        sfrWrEn,
  input logic [7:0]  sfrWrData,
  input logic [7:0]  sfrRdData,
  input logic [7:0]  rdData,
  input logic        offChip,
  input logic [7:0]  pageVal
);

  logic [15:0] chkAddr;
  logic        chkInWin;
  logic        pageHit;

  assign chkAddr  = reqMode ? {pageVal, reqLowAddr} : dataPtr;
  assign chkInWin = (chkAddr >= WIN_BASE);
  assign pageHit  = sfrWrEn && (sfrAddr == PAGE_SFR_ADDR);

  // R8
  off_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !chkInWin) |=> offChip);

  // R8
  off_keeps_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !chkInWin) |=> $stable(rdData));

  // R9
  on_no_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && chkInWin) |=> !offChip);

  // R9
  idle_no_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !offChip);

  // R4
  page_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    pageHit |=> (pageVal == $past(sfrWrData)));

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pageHit |=> $stable(pageVal));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite && chkInWin) |=> $stable(rdData));

  // R3
  sfr_other_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sfrAddr != PAGE_SFR_ADDR) |-> (sfrRdData == 8'h00));

endmodule

bind xram_pager xram_pager_chk #(
  .WIN_BASE(WIN_BASE), .PAGE_SFR_ADDR(PAGE_SFR_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqMode(reqMode), .reqLowAddr(reqLowAddr), .dataPtr(dataPtr),
  .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn), .sfrWrData(sfrWrData),
  .sfrRdData(sfrRdData), .rdData(rdData), .offChip(offChip),
  .pageVal(pageVal)
);

// File: tb/xram_pager_bench.sv
module xram_pager_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RAM_DEPTH  = 3072;
  localparam logic [15:0] BASE = 16'hF400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqMode = 1'b0;
  logic [7:0]  reqLowAddr = '0;
  logic [15:0] dataPtr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  sfrAddr = '0;
  logic        sfrWrEn = 1'b0;
  logic [7:0]  sfrWrData = '0;
  logic [7:0]  sfrRdData, rdData;
  logic        offChip;

  int          checks = 0;
  int          fails  = 0;
  logic [7:0]  model [RAM_DEPTH];
  logic [7:0]  modelPage = 8'h00;
  logic [7:0]  expRd = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  xram_pager u_xram_pager (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMode(reqMode), .reqLowAddr(reqLowAddr), .dataPtr(dataPtr),
    .wrData(wrData), .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn),
    .sfrWrData(sfrWrData), .sfrRdData(sfrRdData), .rdData(rdData),
    .offChip(offChip)
  );

  function automatic logic [15:0] effAddr(input logic m, input logic [7:0] lo,
                                          input logic [15:0] p, input logic [7:0] pg);
    return m ? {pg, lo} : p;
  endfunction

  function automatic logic inWin(input logic [15:0] a);
    return a >= BASE;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request; outputs sampled 1 time unit after the capturing edge.
  task automatic access(input logic m, input logic [7:0] lo, input logic [15:0] p,
                        input logic wr, input logic [7:0] wd, input string req);
    logic [15:0] a;
    @(negedge clk);
    reqValid = 1'b1; reqMode = m; reqLowAddr = lo; dataPtr = p;
    reqWrite = wr; wrData = wd;
    a = effAddr(m, lo, p, modelPage);
    @(posedge clk); #1;
    reqValid = 1'b0;
    if (inWin(a)) begin
      if (wr) model[int'(a - BASE)] = wd;
      else    expRd = model[int'(a - BASE)];
    end
    if (sfrWrEn && sfrAddr == 8'h91) modelPage = sfrWrData;
    sfrWrEn = 1'b0;
    check({req, " offChip"}, {15'd0, offChip}, {15'd0, !inWin(a)});
    check({req, " rdData"}, {8'd0, rdData}, {8'd0, expRd});
  endtask

  task automatic sfrWrite(input logic [7:0] ad, input logic [7:0] d);
    @(negedge clk);
    sfrAddr = ad; sfrWrEn = 1'b1; sfrWrData = d;
    @(posedge clk); #1;
    sfrWrEn = 1'b0;
    if (ad == 8'h91) modelPage = d;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(posedge clk);
    #1;
    // R3 reset state
    sfrAddr = 8'h91;
    #1;
    check("R3 page reset", {8'd0, sfrRdData}, 16'h0000);
    check("R7 rdData reset", {8'd0, rdData}, 16'h0000);
    check("R9 offChip reset", {15'd0, offChip}, 16'h0000);
    rstN = 1'b1;

    // R6 fill whole RAM in pointer mode
    for (int i = 0; i < RAM_DEPTH; i++)
      access(1'b0, 8'h00, BASE + 16'(i), 1'b1, 8'((i * 7 + 3) ^ (i >> 8)), "R6 fill");

    // R10 boundaries, pointer mode
    access(1'b0, 8'h00, 16'hF3FF, 1'b0, 8'h00, "R10 ptr F3FF");
    access(1'b0, 8'h00, 16'hF400, 1'b0, 8'h00, "R10 ptr F400");
    access(1'b0, 8'h00, 16'hFFFF, 1'b0, 8'h00, "R10 ptr FFFF");
    // R9 idle cycle
    @(posedge clk); #1;
    check("R9 idle offChip", {15'd0, offChip}, 16'h0000);

    // R3 page read-back
    sfrWrite(8'h91, 8'hF5);
    sfrAddr = 8'h91; #1;
    check("R3 page readback", {8'd0, sfrRdData}, 16'h00F5);
    sfrAddr = 8'hA0; #1;
    check("R3 other sfr reads zero", {8'd0, sfrRdData}, 16'h0000);

    // R4 same-cycle page write uses old page
    sfrAddr = 8'h91; sfrWrEn = 1'b1; sfrWrData = 8'h12;
    access(1'b1, 8'h10, 16'h0000, 1'b0, 8'h00, "R4 old page");
    access(1'b1, 8'h10, 16'h0000, 1'b0, 8'h00, "R4 new page off-chip");
    // R5 write port 2 latch address, page unchanged
    sfrWrite(8'hA0, 8'hFF);
    sfrAddr = 8'h91; #1;
    check("R5 page after port write", {8'd0, sfrRdData}, 16'h0012);
    // R8 paged off-chip write must not touch RAM
    access(1'b1, 8'h34, 16'h0000, 1'b1, 8'hAA, "R8 off-chip write");

    // R10 boundaries, paged mode; R2 mapping
    sfrWrite(8'h91, 8'hF3);
    access(1'b1, 8'hFF, 16'h0000, 1'b0, 8'h00, "R10 paged F3FF");
    sfrWrite(8'h91, 8'hF4);
    access(1'b1, 8'h00, 16'h0000, 1'b0, 8'h00, "R10 paged F400");
    sfrWrite(8'h91, 8'hFF);
    access(1'b1, 8'hFF, 16'h0000, 1'b0, 8'h00, "R10 paged FFFF");
    access(1'b1, 8'h80, 16'h0000, 1'b1, 8'h5C, "R2 paged write");
    access(1'b0, 8'h00, 16'hFF80, 1'b0, 8'h00, "R2 ptr readback");

    // Random mix: R1 R2 R6 R7 R8 R9
    for (int n = 0; n < 4000; n++) begin
      logic m, w;
      logic [15:0] p;
      m = 1'($urandom);
      w = ($urandom % 3) == 0;
      if (($urandom % 2) == 0) p = BASE + 16'($urandom % RAM_DEPTH);
      else                     p = 16'($urandom);
      if (m && ($urandom % 8) == 0) begin
        if (($urandom % 4) == 0) sfrWrite(8'h91, 8'($urandom));
        else                     sfrWrite(8'h91, 8'hF4 + 8'($urandom % 12));
      end
      if (($urandom % 16) == 0) sfrWrite(8'hA0, 8'($urandom));
      access(m, 8'($urandom), p, w, 8'($urandom), m ? "R2 random paged" : "R1 random ptr");
    end

    // R7 final sweep of every byte, catches stray off-chip writes (R8)
    for (int i = 0; i < RAM_DEPTH; i++)
      access(1'b0, 8'h00, BASE + 16'(i), 1'b0, 8'h00, "R7 sweep");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule